// File: doc/BRIEF.md
# Dual-Retire In-Order Completion Queue with Serialization Classes

This block tracks dispatched instructions in program order and retires them from the oldest end, up to two per cycle. When an instruction is dispatched it takes the next free slot. The slot number is the instruction's tag. Each slot records a serialization class and a finished flag. The execution units report completion by presenting a finish strobe with a tag. Each cycle the queue decides how many of its oldest entries retire, and it reports the count and the tags one cycle later. The rename logic uses these outputs to commit results.

The serialization class decides how many entries may retire together:
- An execution-serialized or sync-serialized entry always retires alone.
- A store-serialized entry retires only from the bottom slot. It may take one plain entry with it in the same cycle.
- Dispatch is cut to a single instruction in any cycle where an offered instruction is serialized.

The queue also drives several status lines:
- A go line tells a serialized instruction's unit that every older instruction has completed.
- A hold line stalls the execution unit while an execution-serialized instruction waits.
- A hold line stalls younger loads and stores while a sync-serialized instruction is in flight.
- A commit strobe releases a store to memory when it retires.

A flush input discards every entry younger than a given tag.

Top module: `cmplq_top`

## Requirements
- R1: After a synchronous active-high reset the queue is empty, `ret_cnt` is 0, `st_commit` is 0, and `exec_go`, `hold_exu` and `hold_lsu` are all 0.
- R2: Dispatch allocates slots in order. Lane 0 gets tag `tail` and lane 1 gets tag `tail+1`, with both tags modulo DEPTH. Lane 1 is granted only together with lane 0. A lane is granted only when it fits in the free slot count, where free slots are DEPTH minus the current entries; slots retiring in the same cycle are not counted as free.
- R3: Class codes are: 0 = none, 1 = execution-serialized, 2 = store-serialized, 3 = sync-serialized. If either offered class is nonzero, at most lane 0 is granted.
- R4: Entries retire strictly from the bottom, and only once finished. The count and tags decided in a cycle appear on `ret_cnt`, `ret_tag0` and `ret_tag1` after the next clock edge. `ret_tag0` is the bottom tag and `ret_tag1` is the next tag.
- R5: A second entry retires alongside the bottom entry only when both are finished, the second entry has class 0, and the bottom entry has class 0 or 2.
- R6: `st_commit` pulses together with `ret_cnt` when the retiring bottom entry has class 2.
- R7: `exec_go` is 1 exactly when the bottom entry has class 1 or 3 and is unfinished. `exec_tag` then gives its tag.
- R8: `hold_exu` is 1 while any entry of class 1 is present and unfinished.
- R9: `hold_lsu` is 1 while any entry of class 3 is present, including one that has finished but not yet retired.
- R10: A flush with an occupied index keeps the entries from the bottom up to and including that index and moves the tail to just after it. In the flush cycle no entry retires and no dispatch is granted.
- R11: A finish strobe whose tag names a free slot has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_req | input | 2 | Dispatch offers; bit 0 is the older lane |
| disp_cls0 | input | 2 | Serialization class of lane 0 |
| disp_cls1 | input | 2 | Serialization class of lane 1 |
| disp_gnt | output | 2 | Lanes accepted this cycle |
| disp_tag0 | output | TW | Tag given to lane 0 |
| disp_tag1 | output | TW | Tag given to lane 1 |
| fin_vld | input | 2 | Finish strobes, two ports |
| fin_tag0 | input | TW | Tag finished on port 0 |
| fin_tag1 | input | TW | Tag finished on port 1 |
| flush_vld | input | 1 | Discard entries younger than flush_idx |
| flush_idx | input | TW | Youngest tag to keep |
| ret_cnt | output | 2 | Entries retired (0, 1 or 2), registered |
| ret_tag0 | output | TW | Tag of first retiring entry |
| ret_tag1 | output | TW | Tag of second retiring entry |
| st_commit | output | 1 | Retiring store may be committed to memory |
| exec_go | output | 1 | Bottom serialized entry may execute |
| exec_tag | output | TW | Tag of that entry |
| hold_exu | output | 1 | Execution unit must not accept new work |
| hold_lsu | output | 1 | Loads and stores behind a sync must wait |

## Verification
The bench drives the block with several stimulus patterns:
- A plain-only stream shows that the queue retires two entries per cycle and accepts two per cycle.
- A mix of stores and plain entries separates a legal store-plus-plain pair from the forbidden store-plus-store and plain-plus-store pairs.
- Streams rich in execution-serialized and sync-serialized entries show single retirement, the go line and both hold lines.
- A slow-finish phase fills the queue, which shows that no lane is granted when the queue is full and that finishes arriving out of order still retire in order.
- Flushes at random depths, together with finish strobes aimed at free slots, show that the tail is truncated and that stray finishes are ignored.

// File: rtl/cmplq_pkg.sv
package cmplq_pkg;
  typedef enum logic [1:0] {
    SER_NONE  = 2'd0,
    SER_EXEC  = 2'd1,
    SER_STORE = 2'd2,
    SER_SYNC  = 2'd3
  } ser_cls_e;

  function automatic logic cls_is_plain(input logic [1:0] c);
    return c == SER_NONE;
  endfunction
endpackage

// File: rtl/cmplq_entries.sv
module cmplq_entries #(
  parameter int DEPTH = 8,
  localparam int TW = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [TW-1:0]         head,
  input  logic [TW:0]           count,
  input  logic [1:0]            wr_en,
  input  logic [TW-1:0]         wr_tag0,
  input  logic [TW-1:0]         wr_tag1,
  input  logic [1:0]            wr_cls0,
  input  logic [1:0]            wr_cls1,
  input  logic [1:0]            fin_vld,
  input  logic [TW-1:0]         fin_tag0,
  input  logic [TW-1:0]         fin_tag1,
  output logic [DEPTH-1:0][1:0] cls_o,
  output logic [DEPTH-1:0]      done_o,
  output logic [DEPTH-1:0]      occ_o
);
  logic [DEPTH-1:0][1:0] cls_mem;
  logic [DEPTH-1:0]      done_q;

  // occupancy: slot offset from head lies below the entry count
  for (genvar i = 0; i < DEPTH; i++) begin : g_occ
    logic [TW-1:0] off;
    assign off      = TW'(i) - head;
    assign occ_o[i] = {1'b0, off} < count;
  end

  // class storage: write-only at dispatch, no reset needed
  always_ff @(posedge clk) begin
    if (wr_en[0]) cls_mem[wr_tag0] <= wr_cls0;
    if (wr_en[1]) cls_mem[wr_tag1] <= wr_cls1;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_done
    logic fin_hit, alloc_hit;
    assign fin_hit   = occ_o[i] &&
                       ((fin_vld[0] && fin_tag0 == TW'(i)) ||
                        (fin_vld[1] && fin_tag1 == TW'(i)));
    assign alloc_hit = (wr_en[0] && wr_tag0 == TW'(i)) ||
                       (wr_en[1] && wr_tag1 == TW'(i));
    always_ff @(posedge clk) begin
      if (rst)            done_q[i] <= 1'b0;
      else if (fin_hit)   done_q[i] <= 1'b1;
      else if (alloc_hit) done_q[i] <= 1'b0;
    end
  end

  assign cls_o  = cls_mem;
  assign done_o = done_q;
endmodule

// File: rtl/cmplq_dispatch.sv
module cmplq_dispatch
  import cmplq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int TW = $clog2(DEPTH)
) (
  input  logic [TW:0]   count,
  input  logic [TW-1:0] tail,
  input  logic [1:0]    req,
  input  logic [1:0]    cls0,
  input  logic [1:0]    cls1,
  input  logic          flush,
  output logic [1:0]    gnt,
  output logic [TW-1:0] tag0,
  output logic [TW-1:0] tag1
);
  logic [TW:0] free_slots;
  logic        pair_ok;

  assign free_slots = (TW+1)'(DEPTH) - count;
  assign pair_ok    = cls_is_plain(cls0) && cls_is_plain(cls1);
  assign tag0       = tail;
  assign tag1       = tail + TW'(1);

  always_comb begin
    gnt = 2'b00;
    if (!flush && req[0] && free_slots >= (TW+1)'(1)) begin
      gnt[0] = 1'b1;
      if (req[1] && pair_ok && free_slots >= (TW+1)'(2)) gnt[1] = 1'b1;
    end
  end
endmodule

// File: rtl/cmplq_retire.sv
module cmplq_retire
  import cmplq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int TW = $clog2(DEPTH)
) (
  input  logic [TW-1:0]         head,
  input  logic [TW:0]           count,
  input  logic [DEPTH-1:0][1:0] cls,
  input  logic [DEPTH-1:0]      done,
  input  logic                  flush,
  output logic [1:0]            ret_n,
  output logic                  store_bot
);
  logic [TW-1:0] h1;
  logic [1:0]    c0, c1;
  logic          r0, r1, bot_pairs;

  assign h1        = head + TW'(1);
  assign c0        = cls[head];
  assign c1        = cls[h1];
  assign bot_pairs = (c0 == SER_NONE) || (c0 == SER_STORE);
  assign r0        = !flush && count >= (TW+1)'(1) && done[head];
  assign r1        = r0 && count >= (TW+1)'(2) && done[h1] &&
                     cls_is_plain(c1) && bot_pairs;
  assign ret_n     = r1 ? 2'd2 : (r0 ? 2'd1 : 2'd0);
  assign store_bot = r0 && (c0 == SER_STORE);
endmodule

// File: rtl/cmplq_holds.sv
module cmplq_holds
  import cmplq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int TW = $clog2(DEPTH)
) (
  input  logic [TW-1:0]         head,
  input  logic [DEPTH-1:0][1:0] cls,
  input  logic [DEPTH-1:0]      done,
  input  logic [DEPTH-1:0]      occ,
  output logic                  exec_go,
  output logic                  hold_exu,
  output logic                  hold_lsu
);
  logic [DEPTH-1:0] exu_wait, sync_live;

  for (genvar i = 0; i < DEPTH; i++) begin : g_scan
    assign exu_wait[i]  = occ[i] && cls[i] == SER_EXEC && !done[i];
    assign sync_live[i] = occ[i] && cls[i] == SER_SYNC;
  end

  assign exec_go  = occ[head] && !done[head] &&
                    (cls[head] == SER_EXEC || cls[head] == SER_SYNC);
  assign hold_exu = |exu_wait;
  assign hold_lsu = |sync_live;
endmodule

// File: rtl/cmplq_top.sv
module cmplq_top #(
  parameter int DEPTH = 8,
  localparam int TW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    disp_req,
  input  logic [1:0]    disp_cls0,
  input  logic [1:0]    disp_cls1,
  output logic [1:0]    disp_gnt,
  output logic [TW-1:0] disp_tag0,
  output logic [TW-1:0] disp_tag1,
  input  logic [1:0]    fin_vld,
  input  logic [TW-1:0] fin_tag0,
  input  logic [TW-1:0] fin_tag1,
  input  logic          flush_vld,
  input  logic [TW-1:0] flush_idx,
  output logic [1:0]    ret_cnt,
  output logic [TW-1:0] ret_tag0,
  output logic [TW-1:0] ret_tag1,
  output logic          st_commit,
  output logic          exec_go,
  output logic [TW-1:0] exec_tag,
  output logic          hold_exu,
  output logic          hold_lsu
);
  logic [TW-1:0]         head;
  logic [TW:0]           count;
  logic [TW-1:0]         tail;
  logic [DEPTH-1:0][1:0] cls;
  logic [DEPTH-1:0]      done, occ;
  logic [1:0]            ret_n;
  logic                  store_bot;
  logic [TW-1:0]         fl_dist;
  logic [TW:0]           n_disp;

  assign tail    = head + count[TW-1:0];
  assign fl_dist = flush_idx - head;
  assign n_disp  = (TW+1)'(disp_gnt[0]) + (TW+1)'(disp_gnt[1]);

  cmplq_entries #(.DEPTH(DEPTH)) u_ent (
    .clk(clk), .rst(rst), .head(head), .count(count),
    .wr_en(disp_gnt), .wr_tag0(disp_tag0), .wr_tag1(disp_tag1),
    .wr_cls0(disp_cls0), .wr_cls1(disp_cls1),
    .fin_vld(fin_vld), .fin_tag0(fin_tag0), .fin_tag1(fin_tag1),
    .cls_o(cls), .done_o(done), .occ_o(occ)
  );

  cmplq_dispatch #(.DEPTH(DEPTH)) u_dsp (
    .count(count), .tail(tail), .req(disp_req),
    .cls0(disp_cls0), .cls1(disp_cls1), .flush(flush_vld),
    .gnt(disp_gnt), .tag0(disp_tag0), .tag1(disp_tag1)
  );

  cmplq_retire #(.DEPTH(DEPTH)) u_ret (
    .head(head), .count(count), .cls(cls), .done(done),
    .flush(flush_vld), .ret_n(ret_n), .store_bot(store_bot)
  );

  cmplq_holds #(.DEPTH(DEPTH)) u_hld (
    .head(head), .cls(cls), .done(done), .occ(occ),
    .exec_go(exec_go), .hold_exu(hold_exu), .hold_lsu(hold_lsu)
  );

  assign exec_tag = head;

  always_ff @(posedge clk) begin
    if (rst) begin
      head      <= '0;
      count     <= '0;
      ret_cnt   <= 2'd0;
      ret_tag0  <= '0;
      ret_tag1  <= '0;
      st_commit <= 1'b0;
    end else begin
      ret_cnt   <= ret_n;
      ret_tag0  <= head;
      ret_tag1  <= head + TW'(1);
      st_commit <= store_bot;
      if (flush_vld) begin
        count <= {1'b0, fl_dist} + (TW+1)'(1);
      end else begin
        head  <= head + TW'(ret_n);
        count <= count - (TW+1)'(ret_n) + n_disp;
      end
    end
  end
endmodule

// File: rtl/cmplq_chk.sv
module cmplq_chk #(
  parameter int DEPTH = 8,
  localparam int TW = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst,
  input logic [TW:0]   count,
  input logic [1:0]    disp_gnt,
  input logic [1:0]    disp_cls0,
  input logic [1:0]    disp_cls1,
  input logic          flush_vld,
  input logic [1:0]    ret_cnt,
  input logic [TW-1:0] ret_tag0,
  input logic [TW-1:0] ret_tag1,
  input logic          st_commit
);
  // R2
  full_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
    count == (TW+1)'(DEPTH) |-> disp_gnt == 2'b00);
  // R2
  lane_order_chk: assert property (@(posedge clk) disable iff (rst)
    disp_gnt[1] |-> disp_gnt[0]);
  // R3
  serial_single_chk: assert property (@(posedge clk) disable iff (rst)
    disp_gnt == 2'b11 |-> (disp_cls0 == 2'd0 && disp_cls1 == 2'd0));
  // R4
  ret_width_chk: assert property (@(posedge clk) disable iff (rst)
    ret_cnt != 2'd3);
  // R4
  ret_adjacent_chk: assert property (@(posedge clk) disable iff (rst)
    ret_cnt == 2'd2 |-> ret_tag1 == ret_tag0 + TW'(1));
  // R6
  commit_with_retire_chk: assert property (@(posedge clk) disable iff (rst)
    st_commit |-> ret_cnt != 2'd0);
  // R10
  flush_no_retire_chk: assert property (@(posedge clk) disable iff (rst)
    flush_vld |=> ret_cnt == 2'd0);
endmodule

bind cmplq_top cmplq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .count(count), .disp_gnt(disp_gnt),
  .disp_cls0(disp_cls0), .disp_cls1(disp_cls1), .flush_vld(flush_vld),
  .ret_cnt(ret_cnt), .ret_tag0(ret_tag0), .ret_tag1(ret_tag1),
  .st_commit(st_commit)
);

// File: tb/sim_cmplq_top.sv
`timescale 1ns/1ps
module sim_cmplq_top;
  localparam int D  = 8;
  localparam int TW = $clog2(D);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    disp_req = '0;
  logic [1:0]    disp_cls0 = '0, disp_cls1 = '0;
  logic [1:0]    disp_gnt;
  logic [TW-1:0] disp_tag0, disp_tag1;
  logic [1:0]    fin_vld = '0;
  logic [TW-1:0] fin_tag0 = '0, fin_tag1 = '0;
  logic          flush_vld = 1'b0;
  logic [TW-1:0] flush_idx = '0;
  logic [1:0]    ret_cnt;
  logic [TW-1:0] ret_tag0, ret_tag1, exec_tag;
  logic          st_commit, exec_go, hold_exu, hold_lsu;

  always #2.5 clk = ~clk;

  cmplq_top #(.DEPTH(D)) u0 (.*);

  int tests = 0, fails = 0;

  // behavioural reference: oldest entry at index 0
  int mcls[$];
  int mdone[$];
  int mhead = 0;
  int e_cnt = 0, e_t0 = 0, e_t1 = 0, e_st = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_state();
    int n = mcls.size();
    int go = 0, hx = 0, hl = 0;
    if (n > 0 && (mcls[0] == 1 || mcls[0] == 3) && mdone[0] == 0) go = 1;
    foreach (mcls[i]) begin
      if (mcls[i] == 1 && mdone[i] == 0) hx = 1;
      if (mcls[i] == 3) hl = 1;
    end
    chk("R4", "ret_cnt", int'(ret_cnt), e_cnt);
    if (e_cnt >= 1) chk("R4", "ret_tag0", int'(ret_tag0), e_t0);
    if (e_cnt == 2) chk("R5", "ret_tag1", int'(ret_tag1), e_t1);
    chk("R6", "st_commit", int'(st_commit), e_st);
    chk("R7", "exec_go", int'(exec_go), go);
    if (go == 1) chk("R7", "exec_tag", int'(exec_tag), mhead);
    chk("R8", "hold_exu", int'(hold_exu), hx);
    chk("R9", "hold_lsu", int'(hold_lsu), hl);
  endtask

  function automatic int pick_cls(input int mode);
    int r = int'($urandom_range(0, 99));
    case (mode)
      0: return 0;
      1: return (r < 50) ? 2 : 0;
      2: return (r < 30) ? 1 : ((r < 45) ? 2 : 0);
      3: return (r < 25) ? 3 : ((r < 40) ? 2 : 0);
      default: return r % 4;
    endcase
  endfunction

  // one cycle: check, drive, check grants, advance model
  task automatic step(input int mode, input int pfin, input int pflush);
    int n, g0, g1, r0, r1, keep, c0, c1;
    @(negedge clk);
    check_state();
    n = mcls.size();
    c0 = pick_cls(mode);
    c1 = pick_cls(mode);
    disp_req  = 2'($urandom_range(0, 3));
    disp_cls0 = 2'(c0);
    disp_cls1 = 2'(c1);
    fin_vld   = 2'b00;
    for (int k = 0; k < 2; k++) begin
      int t;
      if (int'($urandom_range(0, 99)) < pfin) begin
        if (n > 0 && int'($urandom_range(0, 9)) < 8)
          t = (mhead + int'($urandom_range(0, n - 1))) % D;
        else
          t = int'($urandom_range(0, D - 1)); // R11: may hit a free slot
        fin_vld[k] = 1'b1;
        if (k == 0) fin_tag0 = TW'(t); else fin_tag1 = TW'(t);
      end
    end
    flush_vld = 1'b0;
    keep = 0;
    if (n > 0 && int'($urandom_range(0, 99)) < pflush) begin
      keep = int'($urandom_range(0, n - 1));
      flush_vld = 1'b1;
      flush_idx = TW'((mhead + keep) % D);
    end
    #1;
    g0 = (!flush_vld && disp_req[0] && (D - n) >= 1) ? 1 : 0;
    g1 = (g0 == 1 && disp_req[1] && c0 == 0 && c1 == 0 && (D - n) >= 2) ? 1 : 0;
    chk("R2", "gnt0", int'(disp_gnt[0]), g0);
    chk("R3", "gnt1", int'(disp_gnt[1]), g1);
    if (g0 == 1) chk("R2", "tag0", int'(disp_tag0), (mhead + n) % D);
    if (g1 == 1) chk("R2", "tag1", int'(disp_tag1), (mhead + n + 1) % D);
    // retire decision
    r0 = (!flush_vld && n >= 1 && mdone[0] == 1) ? 1 : 0;
    r1 = (r0 == 1 && n >= 2 && mdone[1] == 1 && mcls[1] == 0 &&
          (mcls[0] == 0 || mcls[0] == 2)) ? 1 : 0;
    e_cnt = r0 + r1;
    e_t0  = mhead;
    e_t1  = (mhead + 1) % D;
    e_st  = (r0 == 1 && mcls[0] == 2) ? 1 : 0;
    // advance model
    if (flush_vld) begin
      while (mcls.size() > keep + 1) begin
        void'(mcls.pop_back());
        void'(mdone.pop_back());
      end
    end else begin
      for (int k = 0; k < e_cnt; k++) begin
        void'(mcls.pop_front());
        void'(mdone.pop_front());
      end
      mhead = (mhead + e_cnt) % D;
    end
    for (int k = 0; k < 2; k++) begin
      if (fin_vld[k]) begin
        int p = ((k == 0 ? int'(fin_tag0) : int'(fin_tag1)) - mhead + D) % D;
        if (p < mcls.size()) mdone[p] = 1;
      end
    end
    if (g0 == 1) begin mcls.push_back(c0); mdone.push_back(0); end
    if (g1 == 1) begin mcls.push_back(c1); mdone.push_back(0); end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", "ret_cnt", int'(ret_cnt), 0);
    chk("R1", "st_commit", int'(st_commit), 0);
    chk("R1", "exec_go", int'(exec_go), 0);
    chk("R1", "hold_exu", int'(hold_exu), 0);
    chk("R1", "hold_lsu", int'(hold_lsu), 0);
    rst = 1'b0;
    repeat (600) step(0, 80, 0);   // plain stream, dual retire
    repeat (600) step(1, 70, 0);   // store/plain pairing
    repeat (600) step(2, 60, 0);   // execution-serialized
    repeat (600) step(3, 60, 0);   // sync-serialized
    repeat (400) step(4, 15, 0);   // slow finish: fill queue
    repeat (800) step(4, 60, 8);   // R10 flushes, R11 stray finishes
    repeat (20)  step(0, 0, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule